// File: doc/BRIEF.md
# Software Flow Controller for a Byte Serial Link

This block sits between a byte-wide serial receiver and transmitter on one side and the user's receive and transmit byte queues on the other. It applies in-band pause and resume signalling: the byte 0x13 from the far end means "stop sending", and the byte 0x11 means "carry on". Both are removed from the inbound stream and acted on at once. Every other received byte passes through to the receive queue unchanged.

The block also watches the fill level of the local receive queue. When the level climbs to a high-water mark it asks the far end to stop by sending 0x13. When the level later drains to a low-water mark it sends 0x11. A pending control byte beats user data at the next free transmit slot. It goes out even while the far end holds this side paused, so two sides that have stopped each other can always resume.

The outgoing byte sits in a single holding slot toward the transmitter. Once the slot offers a byte, that byte stays until the transmitter takes it. A control byte therefore never cuts a byte that is already in flight.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset, `paused_o` is 0, `utx_valid_o` is 0 and no control byte is pending, so no transmit byte appears until there is a cause.
- R2: A received byte 0x13 is always accepted (`urx_ready_o` = 1 whatever `rxq_ready_i` is). It is never written to the receive queue, and `paused_o` is 1 from the next cycle.
- R3: A received byte 0x11 is always accepted and never written to the receive queue, and `paused_o` is 0 from the next cycle.
- R4: Any other received byte is offered to the receive queue unchanged (`rxq_valid_o` = `urx_valid_i`, same data). `urx_ready_o` follows `rxq_ready_i`.
- R5: While `paused_o` is 1, no user byte is taken from the transmit queue (`txq_ready_o` = 0).
- R6: When no stop request is in force and `rxq_level_i` >= HIGH_WATER, 0x13 becomes pending. It is sent even while `paused_o` is 1.
- R7: 0x11 becomes pending only when a stop request is in force and `rxq_level_i` <= LOW_WATER. Without an earlier 0x13 request, 0x11 is never sent.
- R8: When the holding slot is free or is being emptied, a pending control byte is loaded in preference to user data. In that cycle `txq_ready_o` is 0.
- R9: While `utx_valid_o` is 1 and `utx_ready_i` is 0, the next cycle still has `utx_valid_o` = 1 with the same `utx_data_o`.
- R10: If a new control request arises while an older one is still unsent, only the newer one is sent.
- R11: User bytes reach the transmitter in queue order. After a resume, the first byte sent is the one that was next when the pause began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| urx_valid_i | input | 1 | Received byte available from serial receiver |
| urx_data_i | input | 8 | Received byte |
| urx_ready_o | output | 1 | Received byte consumed |
| rxq_valid_o | output | 1 | Data byte offered to receive queue |
| rxq_data_o | output | 8 | Data byte to receive queue |
| rxq_ready_i | input | 1 | Receive queue accepts the byte |
| rxq_level_i | input | LEVEL_W | Receive queue fill level |
| txq_valid_i | input | 1 | User byte available in transmit queue |
| txq_data_i | input | 8 | User byte |
| txq_ready_o | output | 1 | User byte taken |
| utx_valid_o | output | 1 | Byte offered to serial transmitter |
| utx_data_o | output | 8 | Byte to serial transmitter |
| utx_ready_i | input | 1 | Transmitter takes the byte |
| paused_o | output | 1 | Far end has asked this side to stop sending user data |

## Verification
The bench builds the block with a 4-bit level, a high-water mark of 10 and a low-water mark of 3. A random walk of the level then crosses both marks many times in a run, and it often hovers between them, which exercises the hysteresis. Received bytes are a quarter control codes, so pause and resume arrive while the holding slot is stalled and while control bytes are pending. Directed phases cover a stop request issued while paused and a request that replaces an unsent one.

// File: rtl/xf_pkg.sv
package xf_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t CODE_RESUME = 8'h11;
  localparam byte_t CODE_STOP   = 8'h13;
  typedef enum logic {CK_RESUME = 1'b0, CK_STOP = 1'b1} ctrl_kind_e;

  function automatic logic is_ctrl(input byte_t b);
    return (b == CODE_RESUME) || (b == CODE_STOP);
  endfunction

  function automatic byte_t kind_code(input ctrl_kind_e k);
    return (k == CK_STOP) ? CODE_STOP : CODE_RESUME;
  endfunction
endpackage

// File: rtl/xf_rx_filter.sv
module xf_rx_filter
  import xf_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  urx_valid_i,
  input  byte_t urx_data_i,
  output logic  urx_ready_o,
  output logic  rxq_valid_o,
  output byte_t rxq_data_o,
  input  logic  rxq_ready_i,
  output logic  paused_o
);
  logic ctrl_hit;
  logic paused_q;

  assign ctrl_hit    = is_ctrl(urx_data_i);
  // control bytes never wait on the queue
  assign urx_ready_o = ctrl_hit ? 1'b1 : rxq_ready_i;
  assign rxq_valid_o = urx_valid_i && !ctrl_hit;
  assign rxq_data_o  = urx_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paused_q <= 1'b0;
    end else if (urx_valid_i && ctrl_hit) begin
      paused_q <= (urx_data_i == CODE_STOP);
    end
  end

  assign paused_o = paused_q;
endmodule

// File: rtl/xf_watermark.sv
module xf_watermark
  import xf_pkg::*;
#(
  parameter int LEVEL_W    = 5,
  parameter int HIGH_WATER = 24,
  parameter int LOW_WATER  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LEVEL_W-1:0] level_i,
  input  logic               take_i,
  output logic               pend_o,
  output ctrl_kind_e         kind_o
);
  localparam logic [LEVEL_W-1:0] HI = LEVEL_W'(HIGH_WATER);
  localparam logic [LEVEL_W-1:0] LO = LEVEL_W'(LOW_WATER);

  logic       stop_q;
  logic       pend_q;
  ctrl_kind_e kind_q;
  logic       req_stop, req_resume;

  assign req_stop   = !stop_q && (level_i >= HI);
  assign req_resume =  stop_q && (level_i <= LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      pend_q <= 1'b0;
      kind_q <= CK_RESUME;
    end else if (req_stop) begin
      stop_q <= 1'b1;
      pend_q <= 1'b1;
      kind_q <= CK_STOP;
    end else if (req_resume) begin
      stop_q <= 1'b0;
      pend_q <= 1'b1;
      kind_q <= CK_RESUME;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign kind_o = kind_q;
endmodule

// File: rtl/xf_tx_arbiter.sv
module xf_tx_arbiter
  import xf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       paused_i,
  input  logic       pend_i,
  input  ctrl_kind_e kind_i,
  output logic       take_o,
  input  logic       txq_valid_i,
  input  byte_t      txq_data_i,
  output logic       txq_ready_o,
  output logic       utx_valid_o,
  output byte_t      utx_data_o,
  input  logic       utx_ready_i
);
  logic  slot_q;
  byte_t data_q;
  logic  load;

  // slot is free or being emptied this cycle
  assign load        = !slot_q || utx_ready_i;
  assign take_o      = load && pend_i;
  assign txq_ready_o = load && !pend_i && !paused_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= 1'b0;
      data_q <= '0;
    end else if (load) begin
      if (pend_i) begin
        slot_q <= 1'b1;
        data_q <= kind_code(kind_i);
      end else if (txq_valid_i && !paused_i) begin
        slot_q <= 1'b1;
        data_q <= txq_data_i;
      end else begin
        slot_q <= 1'b0;
      end
    end
  end

  assign utx_valid_o = slot_q;
  assign utx_data_o  = data_q;
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl
  import xf_pkg::*;
#(
  parameter int LEVEL_W    = 5,
  parameter int HIGH_WATER = 24,
  parameter int LOW_WATER  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               urx_valid_i,
  input  logic [7:0]         urx_data_i,
  output logic               urx_ready_o,
  output logic               rxq_valid_o,
  output logic [7:0]         rxq_data_o,
  input  logic               rxq_ready_i,
  input  logic [LEVEL_W-1:0] rxq_level_i,
  input  logic               txq_valid_i,
  input  logic [7:0]         txq_data_i,
  output logic               txq_ready_o,
  output logic               utx_valid_o,
  output logic [7:0]         utx_data_o,
  input  logic               utx_ready_i,
  output logic               paused_o
);
  logic       paused;
  logic       pend;
  logic       take;
  ctrl_kind_e kind;

  xf_rx_filter u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .urx_valid_i (urx_valid_i),
    .urx_data_i  (urx_data_i),
    .urx_ready_o (urx_ready_o),
    .rxq_valid_o (rxq_valid_o),
    .rxq_data_o  (rxq_data_o),
    .rxq_ready_i (rxq_ready_i),
    .paused_o    (paused)
  );

  xf_watermark #(
    .LEVEL_W    (LEVEL_W),
    .HIGH_WATER (HIGH_WATER),
    .LOW_WATER  (LOW_WATER)
  ) u_wm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (rxq_level_i),
    .take_i  (take),
    .pend_o  (pend),
    .kind_o  (kind)
  );

  xf_tx_arbiter u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .paused_i    (paused),
    .pend_i      (pend),
    .kind_i      (kind),
    .take_o      (take),
    .txq_valid_i (txq_valid_i),
    .txq_data_i  (txq_data_i),
    .txq_ready_o (txq_ready_o),
    .utx_valid_o (utx_valid_o),
    .utx_data_o  (utx_data_o),
    .utx_ready_i (utx_ready_i)
  );

  assign paused_o = paused;
endmodule

// File: rtl/xonxoff_flow_ctrl_chk.sv
module xonxoff_flow_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       urx_valid_i,
  input logic [7:0] urx_data_i,
  input logic       urx_ready_o,
  input logic       rxq_valid_o,
  input logic [7:0] rxq_data_o,
  input logic       txq_ready_o,
  input logic       utx_valid_o,
  input logic [7:0] utx_data_o,
  input logic       utx_ready_i,
  input logic       paused_o
);
  logic rx_ctrl;
  assign rx_ctrl = (urx_data_i == 8'h11) || (urx_data_i == 8'h13);

  AST_CTRL_ALWAYS_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urx_valid_i && rx_ctrl |-> urx_ready_o && !rxq_valid_o); // R2
  AST_STOP_SETS_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urx_valid_i && urx_data_i == 8'h13 |=> paused_o); // R2
  AST_RESUME_CLEARS_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urx_valid_i && urx_data_i == 8'h11 |=> !paused_o); // R3
  AST_DATA_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urx_valid_i && !rx_ctrl |-> rxq_valid_o && rxq_data_o == urx_data_i); // R4
  AST_PAUSE_BLOCKS_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> !txq_ready_o); // R5
  AST_SLOT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    utx_valid_o && !utx_ready_i |=> utx_valid_o && $stable(utx_data_o)); // R9
endmodule

bind xonxoff_flow_ctrl xonxoff_flow_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .urx_valid_i (urx_valid_i),
  .urx_data_i  (urx_data_i),
  .urx_ready_o (urx_ready_o),
  .rxq_valid_o (rxq_valid_o),
  .rxq_data_o  (rxq_data_o),
  .txq_ready_o (txq_ready_o),
  .utx_valid_o (utx_valid_o),
  .utx_data_o  (utx_data_o),
  .utx_ready_i (utx_ready_i),
  .paused_o    (paused_o)
);

// File: tb/xonxoff_flow_ctrl_tb.sv
module xonxoff_flow_ctrl_tb;
  localparam int LW = 4;
  localparam int HW = 10;
  localparam int LWM = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic urx_valid = 1'b0, rxq_ready = 1'b0, txq_valid = 1'b0, utx_ready = 1'b0;
  logic [7:0] urx_data = 8'h00, txq_data = 8'h00;
  logic [LW-1:0] level = '0;
  logic urx_ready, rxq_valid, txq_ready, utx_valid, paused;
  logic [7:0] rxq_data, utx_data;

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R1";

  // reference state
  logic m_paused, m_stop, m_pend, m_kind_stop, m_slot;
  logic [7:0] m_data;
  // queue-order tracking for R11
  logic [7:0] next_user = 8'h40;
  logic [7:0] exp_user  = 8'h40;
  bit order_mode = 1'b0;

  always #2.5 clk = ~clk;

  xonxoff_flow_ctrl #(.LEVEL_W(LW), .HIGH_WATER(HW), .LOW_WATER(LWM)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .urx_valid_i(urx_valid), .urx_data_i(urx_data), .urx_ready_o(urx_ready),
    .rxq_valid_o(rxq_valid), .rxq_data_o(rxq_data), .rxq_ready_i(rxq_ready),
    .rxq_level_i(level),
    .txq_valid_i(txq_valid), .txq_data_i(txq_data), .txq_ready_o(txq_ready),
    .utx_valid_o(utx_valid), .utx_data_o(utx_data), .utx_ready_i(utx_ready),
    .paused_o(paused)
  );

  function automatic bit is_ctl(input logic [7:0] b);
    return (b == 8'h11) || (b == 8'h13);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_paused = 0; m_stop = 0; m_pend = 0; m_kind_stop = 0; m_slot = 0; m_data = 0;
  endtask

  // called after inputs settle, before the rising edge
  task automatic check_and_step();
    logic load, n_paused, n_stop, n_pend, n_kind, n_slot;
    logic [7:0] n_data;
    bit c;
    c = is_ctl(urx_data);
    chk(c ? "R2 R3 ctrl ready" : "R4 ready", {31'd0, urx_ready}, {31'd0, c ? 1'b1 : rxq_ready});
    chk(c ? "R2 R3 not forwarded" : "R4 valid", {31'd0, rxq_valid}, {31'd0, urx_valid && !c});
    if (urx_valid && !c) chk("R4 data", {24'd0, rxq_data}, {24'd0, urx_data});
    chk("R2 R3 pause flag", {31'd0, paused}, {31'd0, m_paused});
    load = !m_slot || utx_ready;
    chk("R5 R8 txq_ready", {31'd0, txq_ready}, {31'd0, load && !m_pend && !m_paused});
    chk({tag, " utx_valid"}, {31'd0, utx_valid}, {31'd0, m_slot});
    if (m_slot) chk({tag, " utx_data"}, {24'd0, utx_data}, {24'd0, m_data});
    if (order_mode && utx_valid && utx_ready && !is_ctl(utx_data)) begin
      chk("R11 order", {24'd0, utx_data}, {24'd0, exp_user});
      exp_user++;
    end
    // next state
    n_paused = m_paused;
    if (urx_valid && urx_data == 8'h13) n_paused = 1;
    else if (urx_valid && urx_data == 8'h11) n_paused = 0;
    n_stop = m_stop; n_pend = m_pend; n_kind = m_kind_stop;
    if (!m_stop && level >= LW'(HW)) begin
      n_stop = 1; n_pend = 1; n_kind = 1;
    end else if (m_stop && level <= LW'(LWM)) begin
      n_stop = 0; n_pend = 1; n_kind = 0;
    end else if (load && m_pend) begin
      n_pend = 0;
    end
    n_slot = m_slot; n_data = m_data;
    if (load) begin
      if (m_pend) begin n_slot = 1; n_data = m_kind_stop ? 8'h13 : 8'h11; end
      else if (txq_valid && !m_paused) begin n_slot = 1; n_data = txq_data; end
      else n_slot = 0;
    end
    if (order_mode && txq_valid && txq_ready) next_user++;
    @(posedge clk);
    m_paused = n_paused; m_stop = n_stop; m_pend = n_pend; m_kind_stop = n_kind;
    m_slot = n_slot; m_data = n_data;
  endtask

  task automatic cyc(input logic uv, input logic [7:0] ud, input logic rr,
                     input logic [LW-1:0] lv, input logic tv, input logic [7:0] td,
                     input logic ur);
    @(negedge clk);
    urx_valid = uv; urx_data = ud; rxq_ready = rr; level = lv;
    txq_valid = tv; txq_data = td; utx_ready = ur;
    #1;
    check_and_step();
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 paused", {31'd0, paused}, 32'd0);
    chk("R1 utx_valid", {31'd0, utx_valid}, 32'd0);
    @(negedge clk); rst_ni = 1'b1;
    tag = "R1";
    repeat (3) cyc(0, 8'h00, 1, 4'd5, 0, 8'h00, 1);

    // R6: pause, then cross high water; stop byte must still be sent
    tag = "R6";
    cyc(1, 8'h13, 0, 4'd5, 1, 8'h21, 1);
    repeat (2) cyc(0, 8'h00, 1, 4'd5, 1, 8'h21, 1);
    cyc(0, 8'h00, 1, 4'd10, 1, 8'h21, 1);
    repeat (3) cyc(0, 8'h00, 1, 4'd8, 1, 8'h21, 1);
    cyc(1, 8'h11, 0, 4'd8, 1, 8'h22, 1);
    repeat (3) cyc(0, 8'h00, 1, 4'd8, 0, 8'h00, 1);

    // R7: hover above low water; no resume byte yet; then drop
    tag = "R7";
    repeat (4) cyc(0, 8'h00, 1, 4'd6, 0, 8'h00, 1);
    cyc(0, 8'h00, 1, 4'd3, 0, 8'h00, 1);
    repeat (3) cyc(0, 8'h00, 1, 4'd3, 0, 8'h00, 1);

    // R10: slot stalled, stop request then resume request before send
    tag = "R10";
    cyc(0, 8'h00, 1, 4'd5, 1, 8'h55, 1);
    cyc(0, 8'h00, 1, 4'd5, 0, 8'h00, 0);
    cyc(0, 8'h00, 1, 4'd12, 0, 8'h00, 0);
    cyc(0, 8'h00, 1, 4'd8, 0, 8'h00, 0);
    cyc(0, 8'h00, 1, 4'd2, 0, 8'h00, 0);
    repeat (2) cyc(0, 8'h00, 1, 4'd2, 0, 8'h00, 0);
    repeat (4) cyc(0, 8'h00, 1, 4'd2, 0, 8'h00, 1);

    // R11: ordered user stream with pauses interleaved
    tag = "R11";
    order_mode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [7:0] rb;
      int r;
      r = $urandom_range(0, 15);
      rb = (r == 0) ? 8'h13 : (r == 1) ? 8'h11 : 8'h30;
      cyc(r < 3, rb, 1, 4'd5, 1, next_user, $urandom_range(0, 3) != 0);
    end
    cyc(1, 8'h11, 1, 4'd5, 0, 8'h00, 1);
    repeat (3) cyc(0, 8'h00, 1, 4'd5, 0, 8'h00, 1);
    order_mode = 1'b0;

    // random mix: R8 priority and R9 hold under stalls
    tag = "R8 R9";
    for (int i = 0; i < 4000; i++) begin
      logic [LW-1:0] lv;
      logic [7:0] rb;
      int st;
      st = $urandom_range(0, 2);
      lv = level;
      if (st == 0 && lv != '0) lv = lv - 1'b1;
      else if (st == 2 && lv != '1) lv = lv + 1'b1;
      rb = $urandom_range(0, 255);
      if ($urandom_range(0, 3) == 0) rb = $urandom_range(0, 1) ? 8'h11 : 8'h13;
      cyc($urandom_range(0, 1), rb, $urandom_range(0, 1), lv,
          $urandom_range(0, 1), 8'($urandom_range(0, 255)), $urandom_range(0, 2) != 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule